// File: doc/BRIEF.md
# ECC Codeword Fault Injector

This block sits on both paths between a memory controller and a memory that stores 72-bit SECDED codewords: 64 data bits in codeword bits 63:0 and 8 check bits in codeword bits 71:64. Most traffic crosses it unchanged. When the injector is armed and an access hits the programmed target word address, it inverts one or two chosen codeword bits.

In write mode it corrupts the codeword on its way into storage. In read mode it corrupts the codeword coming back from storage, on its way to the decoder, and the stored copy stays intact. This gives the ECC logic downstream a known single-bit or double-bit error to detect or correct.

Each 8-bit bit pointer uses Hamming-position numbering. Position 0 and every power of two up to 0x40 select check bits 0..7, in ascending order. Every other position from 0x03 to 0x47 selects the next data bit, counting up from data bit 0. Positions 0x48 and above select nothing.

Both paths are valid/ready streams and are pure wires with no storage:
- `*_out_valid` follows `*_in_valid`.
- `*_in_ready` follows `*_out_ready`.
- Under back-pressure the upstream side must hold its payload stable. The block never drops or duplicates a beat.

A capture register records the most recent faulted beat, that is, one that was accepted with valid and ready both high.

Top module: `ecc_fault_injector`

## Requirements
- R1: A write beat leaves the block with unchanged address and codeword in each of these cases: the injector is disabled, the mode is read, or the address differs from the target.
- R2: A read beat leaves the block with unchanged address and codeword in each of these cases: the injector is disabled, the mode is write, or the address differs from the target.
- R3: On both paths, out_valid equals in_valid and in_ready equals out_ready in the same cycle, and payload passes combinationally.
- R4: A pointer value of 0x00, 0x01, 0x02, 0x04, 0x08, 0x10, 0x20 or 0x40 flips check bit k = 0..7 (in that order), which is codeword bit 64+k.
- R5: Any other pointer value p from 0x03 to 0x47 flips data bit n (codeword bit n). Here n counts the non-check positions below p, so 0x03→0, 0x05→1, 0x09→4, 0x11→11, 0x21→26, 0x41→57 and 0x47→63.
- R6: A pointer value of 0x48 to 0xFF flips no bit.
- R7: In single mode (cfg_double=0), only pointer A acts, and pointer B has no effect on the codeword.
- R8: In double mode, the flipped bits are the union of the bits selected by pointers A and B. Equal pointers therefore flip one bit only.
- R9: With cfg_on_write=1, only the write path is corrupted. With cfg_on_write=0, only the read path is corrupted.
- R10: While cfg_en=0, no bit is flipped and the capture register does not change.
- R11: When a faulted beat is accepted, cap_flag becomes 1 and cap_addr and cap_is_write (1 = write, 0 = read) take that beat's values on the next clock. Otherwise the capture register holds.
- R12: A cap_clr pulse clears cap_flag on the next clock. If a faulted beat is accepted in the same cycle, the flag stays set.
- R13: After reset, cap_flag, cap_is_write and cap_addr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Global injector enable |
| cfg_on_write | input | 1 | 1: corrupt writes, 0: corrupt reads |
| cfg_double | input | 1 | 1: use both pointers, 0: pointer A only |
| cfg_target | input | ADDR_W | Target word address |
| cfg_ptr_a | input | PTR_W | First bit pointer |
| cfg_ptr_b | input | PTR_W | Second bit pointer |
| wr_in_valid | input | 1 | Write beat valid from controller |
| wr_in_ready | output | 1 | Write beat ready to controller |
| wr_in_addr | input | ADDR_W | Write word address |
| wr_in_code | input | DATA_W+ECC_W | Write codeword from encoder |
| wr_out_valid | output | 1 | Write beat valid to memory |
| wr_out_ready | input | 1 | Write beat ready from memory |
| wr_out_addr | output | ADDR_W | Write address to memory |
| wr_out_code | output | DATA_W+ECC_W | Possibly corrupted write codeword |
| rd_in_valid | input | 1 | Read response valid from memory |
| rd_in_ready | output | 1 | Read response ready to memory |
| rd_in_addr | input | ADDR_W | Word address of the read response |
| rd_in_code | input | DATA_W+ECC_W | Codeword read from memory |
| rd_out_valid | output | 1 | Read response valid to decoder |
| rd_out_ready | input | 1 | Read response ready from decoder |
| rd_out_addr | output | ADDR_W | Word address to decoder |
| rd_out_code | output | DATA_W+ECC_W | Possibly corrupted read codeword |
| cap_clr | input | 1 | Write-one pulse that clears cap_flag |
| cap_flag | output | 1 | Sticky flag for a faulted access |
| cap_is_write | output | 1 | Direction of the last faulted access |
| cap_addr | output | ADDR_W | Address of the last faulted access |

## Verification
The bench sweeps all 256 pointer values in single mode on both paths. It derives the expected flip position by walking the Hamming positions, a method independent of the decoder arithmetic. This exposes an off-by-one at a power-of-two boundary, which would move the flip to a neighbouring data bit or check bit. It also exposes a missing range limit, which would let pointers 0x48 and above corrupt data.

Double-mode pairs include equal pointers and out-of-range partners. An XOR-of-masks design would cancel the flip for equal pointers, and a design that ignored the mode would let pointer B leak into single mode. The bench also checks the following cases:
- Wrong direction, non-target address and disabled injector.
- A beat stalled by back-pressure, which must not capture.
- A clear pulse arriving in the same cycle as a new fault, which a clear-wins design would lose.

// File: rtl/fi_pkg.sv
package fi_pkg;
  typedef enum logic {
    FI_DIR_READ  = 1'b0,
    FI_DIR_WRITE = 1'b1
  } fi_dir_e;
endpackage

// File: rtl/fi_ptr_decode.sv
// Hamming-position pointer to one-hot codeword flip mask.
module fi_ptr_decode #(
  parameter int DATA_W = 64,
  parameter int ECC_W  = 8,
  parameter int PTR_W  = 8
) (
  input  logic [PTR_W-1:0]        ptr,
  output logic [DATA_W+ECC_W-1:0] mask
);
  localparam int CODE_W = DATA_W + ECC_W;

  int  msb;
  int  pval;
  logic pow2;

  always_comb begin
    msb = 0;
    for (int i = 0; i < PTR_W; i++) begin
      if (ptr[i]) msb = i;
    end
    pval = int'(ptr);
    pow2 = ((ptr & (ptr - PTR_W'(1))) == '0);
    mask = '0;
    if (pval == 0) begin
      mask[DATA_W] = 1'b1;                 // position 0: check bit 0
    end else if (pval < CODE_W) begin
      if (pow2) mask[DATA_W + msb + 1] = 1'b1;   // position 2^m: check bit m+1
      else      mask[pval - msb - 2]   = 1'b1;   // skip the m+2 check positions below
    end
  end
endmodule

// File: rtl/fi_path.sv
// One valid/ready path with conditional bit inversion at the target address.
module fi_path #(
  parameter int CODE_W = 72,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic [ADDR_W-1:0] target,
  input  logic [CODE_W-1:0] flip_mask,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [CODE_W-1:0] out_code,
  output logic              fault_fire
);
  logic hit;

  always_comb begin
    hit        = armed && (in_addr == target);
    out_valid  = in_valid;
    in_ready   = out_ready;
    out_addr   = in_addr;
    out_code   = hit ? (in_code ^ flip_mask) : in_code;
    fault_fire = hit && in_valid && out_ready;
  end

  // R1 / R2: traffic that misses the target leaves untouched
  a_r1_miss_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (out_code == in_code));

  // R8: never more than two bits differ across the path
  a_r8_flip_weight: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_code ^ in_code) <= 2);
endmodule

// File: rtl/fi_capture.sv
// Sticky record of the most recent faulted beat.
module fi_capture #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              rd_fire,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              clr,
  output logic              flag,
  output logic              is_write,
  output logic [ADDR_W-1:0] addr
);
  import fi_pkg::*;

  logic evt;
  assign evt = wr_fire || rd_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag     <= 1'b0;
      is_write <= FI_DIR_READ;
      addr     <= '0;
    end else begin
      if (evt) begin
        flag     <= 1'b1;
        is_write <= wr_fire ? FI_DIR_WRITE : FI_DIR_READ;
        addr     <= wr_fire ? wr_addr : rd_addr;
      end else if (clr) begin
        flag <= 1'b0;
      end
    end
  end

  a_r11_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);

  a_r12_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !flag);

  a_r11_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && !clr) |=> ($stable(flag) && $stable(addr) && $stable(is_write)));
endmodule

// File: rtl/ecc_fault_injector.sv
module ecc_fault_injector #(
  parameter int DATA_W = 64,
  parameter int ECC_W  = 8,
  parameter int PTR_W  = 8,
  parameter int ADDR_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_en,
  input  logic                     cfg_on_write,
  input  logic                     cfg_double,
  input  logic [ADDR_W-1:0]        cfg_target,
  input  logic [PTR_W-1:0]         cfg_ptr_a,
  input  logic [PTR_W-1:0]         cfg_ptr_b,
  input  logic                     wr_in_valid,
  output logic                     wr_in_ready,
  input  logic [ADDR_W-1:0]        wr_in_addr,
  input  logic [DATA_W+ECC_W-1:0]  wr_in_code,
  output logic                     wr_out_valid,
  input  logic                     wr_out_ready,
  output logic [ADDR_W-1:0]        wr_out_addr,
  output logic [DATA_W+ECC_W-1:0]  wr_out_code,
  input  logic                     rd_in_valid,
  output logic                     rd_in_ready,
  input  logic [ADDR_W-1:0]        rd_in_addr,
  input  logic [DATA_W+ECC_W-1:0]  rd_in_code,
  output logic                     rd_out_valid,
  input  logic                     rd_out_ready,
  output logic [ADDR_W-1:0]        rd_out_addr,
  output logic [DATA_W+ECC_W-1:0]  rd_out_code,
  input  logic                     cap_clr,
  output logic                     cap_flag,
  output logic                     cap_is_write,
  output logic [ADDR_W-1:0]        cap_addr
);
  localparam int CODE_W = DATA_W + ECC_W;

  logic [CODE_W-1:0] mask_a, mask_b, mask_all;
  logic              wr_fire, rd_fire;

  fi_ptr_decode #(.DATA_W(DATA_W), .ECC_W(ECC_W), .PTR_W(PTR_W)) u_dec_a (
    .ptr(cfg_ptr_a), .mask(mask_a));
  fi_ptr_decode #(.DATA_W(DATA_W), .ECC_W(ECC_W), .PTR_W(PTR_W)) u_dec_b (
    .ptr(cfg_ptr_b), .mask(mask_b));

  // OR, not XOR: equal pointers still flip one bit
  assign mask_all = cfg_double ? (mask_a | mask_b) : mask_a;

  fi_path #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_wr (
    .clk(clk), .rst_n(rst_n),
    .armed(cfg_en && cfg_on_write), .target(cfg_target), .flip_mask(mask_all),
    .in_valid(wr_in_valid), .in_ready(wr_in_ready),
    .in_addr(wr_in_addr), .in_code(wr_in_code),
    .out_valid(wr_out_valid), .out_ready(wr_out_ready),
    .out_addr(wr_out_addr), .out_code(wr_out_code),
    .fault_fire(wr_fire));

  fi_path #(.CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .armed(cfg_en && !cfg_on_write), .target(cfg_target), .flip_mask(mask_all),
    .in_valid(rd_in_valid), .in_ready(rd_in_ready),
    .in_addr(rd_in_addr), .in_code(rd_in_code),
    .out_valid(rd_out_valid), .out_ready(rd_out_ready),
    .out_addr(rd_out_addr), .out_code(rd_out_code),
    .fault_fire(rd_fire));

  fi_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(wr_fire), .wr_addr(wr_in_addr),
    .rd_fire(rd_fire), .rd_addr(rd_in_addr),
    .clr(cap_clr),
    .flag(cap_flag), .is_write(cap_is_write), .addr(cap_addr));

  // R4 / R5 / R6: each pointer selects at most one bit
  a_r5_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_a) && $onehot0(mask_b));

  // R10: disabled injector never corrupts
  a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> (wr_out_code == wr_in_code && rd_out_code == rd_in_code));

  // R9: only the selected direction is touched
  a_r9_direction: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_on_write |-> (rd_out_code == rd_in_code));

  // R7: single mode flips at most one bit on either path
  a_r7_single_weight: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_double |-> ($countones(wr_out_code ^ wr_in_code) <= 1 &&
                     $countones(rd_out_code ^ rd_in_code) <= 1));
endmodule

// File: tb/sim_ecc_fault_injector.sv
`timescale 1ns/1ps
module sim_ecc_fault_injector;
  localparam int AW = 16;
  localparam int CW = 72;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_en = 0, cfg_on_write = 0, cfg_double = 0;
  logic [AW-1:0] cfg_target = 16'h0123;
  logic [7:0]    cfg_ptr_a = 0, cfg_ptr_b = 0;
  logic          wr_in_valid = 0, wr_out_ready = 1;
  logic [AW-1:0] wr_in_addr = 0;
  logic [CW-1:0] wr_in_code = 0;
  logic          rd_in_valid = 0, rd_out_ready = 1;
  logic [AW-1:0] rd_in_addr = 0;
  logic [CW-1:0] rd_in_code = 0;
  logic          cap_clr = 0;
  logic          wr_in_ready, wr_out_valid, rd_in_ready, rd_out_valid;
  logic [AW-1:0] wr_out_addr, rd_out_addr, cap_addr;
  logic [CW-1:0] wr_out_code, rd_out_code;
  logic          cap_flag, cap_is_write;

  always #5 clk = ~clk;

  ecc_fault_injector u0 (.*);

  int n_chk = 0, n_bad = 0;
  int pos_map [256];
  logic [CW-1:0] base = {8'hA5, 64'h0123_4567_89AB_CDEF};

  task automatic chk(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] pmask(int p);
    if (pos_map[p] < 0) return '0;
    return CW'(1) << pos_map[p];
  endfunction

  function automatic string cat(int p);
    if (pos_map[p] < 0)   return "R6";
    if (pos_map[p] >= 64) return "R4";
    return "R5";
  endfunction

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // Expected pointer map: walk positions, check slots at 0 and powers of two
    begin
      int ek, dk;
      ek = 0; dk = 0;
      for (int p = 0; p < 256; p++) pos_map[p] = -1;
      for (int p = 0; p < CW; p++) begin
        if (p == 0 || (p & (p - 1)) == 0) begin pos_map[p] = 64 + ek; ek++; end
        else begin pos_map[p] = dk; dk++; end
      end
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R13 flag", CW'(cap_flag), '0);
    chk("R13 dir", CW'(cap_is_write), '0);
    chk("R13 addr", CW'(cap_addr), '0);
    rst_n = 1'b1;

    // R3 handshake pass-through
    wr_in_valid = 1; wr_out_ready = 0; wr_in_addr = 16'h0042; wr_in_code = base;
    #1;
    chk("R3 wr ready low", CW'(wr_in_ready), '0);
    chk("R3 wr valid", CW'(wr_out_valid), CW'(1));
    chk("R3 wr addr", CW'(wr_out_addr), CW'(16'h0042));
    rd_in_valid = 1; rd_out_ready = 1;
    #1;
    chk("R3 rd ready", CW'(rd_in_ready), CW'(1));
    chk("R3 rd valid", CW'(rd_out_valid), CW'(1));
    wr_in_valid = 0; rd_in_valid = 0; wr_out_ready = 1;

    // Single-mode sweep, write path (R4 R5 R6 R7)
    cfg_en = 1; cfg_on_write = 1; cfg_double = 0; cfg_ptr_b = 8'h05;
    wr_in_addr = cfg_target; wr_in_code = base;
    for (int p = 0; p < 256; p++) begin
      cfg_ptr_a = 8'(p); #1;
      chk({cat(p), " wr single R7"}, wr_out_code, base ^ pmask(p));
    end
    // Single-mode sweep, read path, read mode (R9)
    cfg_on_write = 0; rd_in_addr = cfg_target; rd_in_code = ~base;
    for (int p = 0; p < 256; p++) begin
      cfg_ptr_a = 8'(p); #1;
      chk({cat(p), " rd single R9"}, rd_out_code, ~base ^ pmask(p));
    end

    // Double mode pairs (R8)
    cfg_double = 1; cfg_on_write = 1;
    for (int a = 0; a < 80; a++) begin
      int bl [5];
      bl = '{0, 3, a, 71, 80};
      foreach (bl[k]) begin
        cfg_ptr_a = 8'(a); cfg_ptr_b = 8'(bl[k]); #1;
        chk("R8 double", wr_out_code, base ^ (pmask(a) | pmask(bl[k])));
      end
    end

    // Direction and address gating (R1 R2 R9 R10)
    cfg_ptr_a = 8'h03; cfg_ptr_b = 8'h40;
    rd_in_addr = cfg_target; rd_in_code = base; #1;
    chk("R9 read untouched in write mode R2", rd_out_code, base);
    cfg_on_write = 0; wr_in_addr = cfg_target; #1;
    chk("R9 write untouched in read mode R1", wr_out_code, base);
    cfg_on_write = 1; wr_in_addr = 16'h0124; #1;
    chk("R1 non-target write", wr_out_code, base);
    cfg_on_write = 0; rd_in_addr = 16'h0122; #1;
    chk("R2 non-target read", rd_out_code, base);
    cfg_en = 0; rd_in_addr = cfg_target; wr_in_addr = cfg_target; #1;
    chk("R10 read off", rd_out_code, base);
    cfg_on_write = 1; #1;
    chk("R10 write off", wr_out_code, base);

    // R10: disabled, accepted beat does not capture
    @(negedge clk); wr_in_valid = 1;
    @(negedge clk); wr_in_valid = 0;
    chk("R10 no capture", CW'(cap_flag), '0);

    // R11: stalled beat does not capture
    cfg_en = 1; cfg_on_write = 0; rd_in_valid = 1; rd_out_ready = 0;
    @(negedge clk);
    chk("R11 stalled no capture", CW'(cap_flag), '0);
    rd_out_ready = 1; rd_in_addr = cfg_target;
    @(negedge clk); rd_in_valid = 0;
    chk("R11 flag", CW'(cap_flag), CW'(1));
    chk("R11 dir read", CW'(cap_is_write), '0);
    chk("R11 addr", CW'(cap_addr), CW'(cfg_target));
    @(negedge clk);
    chk("R11 hold", CW'(cap_flag), CW'(1));

    // R12: clear
    cap_clr = 1; @(negedge clk); cap_clr = 0;
    chk("R12 cleared", CW'(cap_flag), '0);
    chk("R12 addr kept", CW'(cap_addr), CW'(cfg_target));

    // R12: new write fault wins over simultaneous clear
    cfg_target = 16'h7E01; cfg_on_write = 1; wr_in_addr = 16'h7E01;
    wr_in_valid = 1; cap_clr = 1;
    @(negedge clk); wr_in_valid = 0; cap_clr = 0;
    chk("R12 set wins", CW'(cap_flag), CW'(1));
    chk("R11 dir write", CW'(cap_is_write), CW'(1));
    chk("R11 new addr", CW'(cap_addr), CW'(16'h7E01));

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule